// File: doc/BRIEF.md
# Posted Write Line Accumulator

This block sits on the inbound side of a bridge and gathers posted memory write beats into a single cache-line buffer. Each byte of the buffer carries its own enable bit. The master's write completes as soon as its beats are accepted. Later stages only ever see whole packets, and each packet is at most one cache line.

A burst opens with a start beat that carries the word address and the command. Later beats fill consecutive words in linear order. The buffer is handed upstream as one packet when the burst reaches the last word of a line or when the master disconnects. A burst that runs past the end of a line is split: the filled line leaves, and the following beats go into a fresh buffer for the next line.

A write-and-invalidate that covers a whole aligned line is tagged as full, so that the next stage can skip merging. A malformed write-and-invalidate is still forwarded, but as a partial packet, and an error pulse is raised. I/O writes and the reserved command are not claimed: their beats are drained and no packet is produced.

Top module: `wline_accum`

## Requirements
- R1: While reset is held and just after it, outValid, cmdReject and wiError are 0 and inReady is 1.
- R2: The start beat's inAddr (a 4-byte word address) selects the line (inAddr[29:3] goes to outLineAddr) and the word (inAddr[2:0]). Each later beat fills the next word, and inAddr and inCmd on later beats are ignored.
- R3: Bit i of inBe writes byte lane inData[8i+7:8i] into line byte 4*word+i and sets bit 4*word+i of outMask. Bytes whose mask bit is 0 read as zero in outData.
- R4: A claimed beat that lands on word 7 closes the packet. If the burst goes on, its next beat starts a new packet on the next line at word 0.
- R5: A claimed beat with inLast=1 closes the packet at whatever word it lands on.
- R6: outValid rises in the cycle after the closing beat's handshake. The packet stays stable until a cycle with outReady=1.
- R7: While outValid=1 and outReady=0, inReady is 0. Otherwise inReady is 1.
- R8: inCmd 2'b00 is a memory write and 2'b01 is a write-and-invalidate. 2'b10 (I/O write) and 2'b11 are not claimed: their beats are accepted until inLast and produce no packet, and cmdReject pulses for one cycle after the start beat.
- R9: outFull is 1 only for a write-and-invalidate line that starts at word 0 and has all eight beats with inBe=4'hF. A plain write never sets outFull.
- R10: A write-and-invalidate line that starts misaligned, ends early, or has any beat with inBe other than 4'hF is sent with outFull=0. wiError pulses in the same cycle that the packet's outValid rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Write beat present |
| inReady | output | 1 | Beat accepted this cycle when inValid is high |
| inAddr | input | 30 | Word address of the burst, used on the start beat only |
| inCmd | input | 2 | Command of the burst, used on the start beat only |
| inData | input | 32 | Beat data |
| inBe | input | 4 | Byte enables of the beat |
| inLast | input | 1 | Final beat of the burst (master disconnect) |
| outValid | output | 1 | Packet available |
| outReady | input | 1 | Upstream takes the packet |
| outLineAddr | output | 27 | Line address of the packet |
| outData | output | 256 | Line data, unwritten bytes zero |
| outMask | output | 32 | Written-byte mask |
| outFull | output | 1 | Complete write-and-invalidate line |
| cmdReject | output | 1 | Pulse: unclaimed burst seen |
| wiError | output | 1 | Pulse: malformed write-and-invalidate line |

## Verification
A wrong word pointer or line pointer shows up in the next packet as data in the wrong byte lanes or as a wrong outLineAddr. It also shows as a packet that closes early or late, at the very next outValid rise. A stale mask or unflushed buffer bytes leak into the following packet as set mask bits or nonzero unwritten bytes. A corrupted alignment or enable tracking bit for a write-and-invalidate shows as a wrong outFull or a missing or spurious wiError, in the cycle the packet appears. A burst-state error shows as claimed beats being dropped, or rejected beats producing packets, within one cycle of the start beat.

// File: rtl/wline_pkg.sv
package wline_pkg;

  typedef enum logic [1:0] {
    CMD_WRITE     = 2'b00,
    CMD_WRITE_INV = 2'b01,
    CMD_IO_WRITE  = 2'b10,
    CMD_RESERVED  = 2'b11
  } wcmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic first;   // beat is the start of a burst
    logic write;   // claimed beat is merged this cycle
    logic flush;   // beat closes the line packet
    logic full;    // packet is a complete write-and-invalidate line
  } strb_t;

endpackage

// File: rtl/wline_ctrl.sv
module wline_ctrl
  import wline_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 4,
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES,
  localparam int WORD_W = $clog2(BEATS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  inLast,
  input  logic [1:0]            inCmd,
  input  logic [BEAT_BYTES-1:0] inBe,
  input  logic [WORD_W-1:0]     beatWord,
  input  logic                  outValid,
  input  logic                  outReady,
  output logic                  inReady,
  output strb_t                 strb,
  output logic                  cmdReject,
  output logic                  wiError
);

  typedef enum logic [1:0] {S_IDLE, S_ACCUM, S_DROP} state_e;

  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(BEATS - 1);

  state_e state;
  logic   isInv;
  logic   lineOk;

  logic take, first, claimed, beatInv, beatOk, atEdge;
  logic doWrite, doFlush, doFull;

  always_comb begin
    inReady = !outValid || outReady;
    take    = inValid && inReady;
    first   = (state == S_IDLE);
    claimed = first ? (inCmd == CMD_WRITE || inCmd == CMD_WRITE_INV)
                    : (state == S_ACCUM);
    beatInv = first ? (inCmd == CMD_WRITE_INV) : isInv;
    beatOk  = (first ? (beatWord == '0) : lineOk) && (&inBe);
    atEdge  = (beatWord == LAST_WORD);
    doWrite = take && claimed;
    doFlush = doWrite && (inLast || atEdge);
    doFull  = doFlush && beatInv && beatOk && atEdge;
    strb    = '{first: first, write: doWrite, flush: doFlush, full: doFull};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      isInv     <= 1'b0;
      lineOk    <= 1'b0;
      cmdReject <= 1'b0;
      wiError   <= 1'b0;
    end else begin
      cmdReject <= take && first && !claimed;
      wiError   <= doFlush && beatInv && !doFull;
      if (take) begin
        if (first) begin
          if (inLast)       state <= S_IDLE;
          else if (claimed) state <= S_ACCUM;
          else              state <= S_DROP;
        end else if (inLast) begin
          state <= S_IDLE;
        end
      end
      if (doWrite) begin
        isInv  <= beatInv;
        lineOk <= doFlush ? 1'b1 : beatOk;
      end
    end
  end

endmodule

// File: rtl/wline_datapath.sv
module wline_datapath
  import wline_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 4,
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
  localparam int WORD_W     = $clog2(BEATS),
  localparam int BEAT_OFF_W = $clog2(BEAT_BYTES),
  localparam int WADDR_W    = ADDR_W - BEAT_OFF_W,
  localparam int LINE_W     = WADDR_W - WORD_W,
  localparam int LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strb_t                   strb,
  input  logic [WADDR_W-1:0]      inAddr,
  input  logic [BEAT_BYTES*8-1:0] inData,
  input  logic [BEAT_BYTES-1:0]   inBe,
  input  logic                    outReady,
  output logic [WORD_W-1:0]       beatWord,
  output logic                    outValid,
  output logic [LINE_W-1:0]       outLineAddr,
  output logic [LINE_BITS-1:0]    outData,
  output logic [LINE_BYTES-1:0]   outMask,
  output logic                    outFull
);

  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(BEATS - 1);

  logic [WORD_W-1:0]     ptrWord;
  logic [LINE_W-1:0]     ptrLine;
  logic [LINE_W-1:0]     beatLine;
  logic [LINE_BITS-1:0]  bufData,  mergeData;
  logic [LINE_BYTES-1:0] bufMask,  mergeMask;

  assign beatWord = strb.first ? inAddr[WORD_W-1:0] : ptrWord;
  assign beatLine = strb.first ? inAddr[WADDR_W-1:WORD_W] : ptrLine;

  // one byte lane per (word, byte) position of the line
  for (genvar w = 0; w < BEATS; w++) begin : g_word
    for (genvar b = 0; b < BEAT_BYTES; b++) begin : g_byte
      localparam int IDX = w * BEAT_BYTES + b;
      logic hit;
      assign hit = strb.write && (beatWord == WORD_W'(w)) && inBe[b];
      assign mergeData[IDX*8 +: 8] = hit ? inData[b*8 +: 8] : bufData[IDX*8 +: 8];
      assign mergeMask[IDX]        = bufMask[IDX] | hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrWord     <= '0;
      ptrLine     <= '0;
      bufData     <= '0;
      bufMask     <= '0;
      outValid    <= 1'b0;
      outLineAddr <= '0;
      outData     <= '0;
      outMask     <= '0;
      outFull     <= 1'b0;
    end else begin
      if (strb.write) begin
        ptrWord <= beatWord + WORD_W'(1);
        ptrLine <= (beatWord == LAST_WORD) ? beatLine + LINE_W'(1) : beatLine;
        if (strb.flush) begin
          bufData <= '0;
          bufMask <= '0;
        end else begin
          bufData <= mergeData;
          bufMask <= mergeMask;
        end
      end
      if (strb.flush) begin
        outValid    <= 1'b1;
        outLineAddr <= beatLine;
        outData     <= mergeData;
        outMask     <= mergeMask;
        outFull     <= strb.full;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wline_accum.sv
module wline_accum
  import wline_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 4,
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
  localparam int WORD_W     = $clog2(BEATS),
  localparam int BEAT_OFF_W = $clog2(BEAT_BYTES),
  localparam int WADDR_W    = ADDR_W - BEAT_OFF_W,
  localparam int LINE_W     = WADDR_W - WORD_W,
  localparam int LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [WADDR_W-1:0]      inAddr,
  input  logic [1:0]              inCmd,
  input  logic [BEAT_BYTES*8-1:0] inData,
  input  logic [BEAT_BYTES-1:0]   inBe,
  input  logic                    inLast,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [LINE_W-1:0]       outLineAddr,
  output logic [LINE_BITS-1:0]    outData,
  output logic [LINE_BYTES-1:0]   outMask,
  output logic                    outFull,
  output logic                    cmdReject,
  output logic                    wiError
);

  strb_t             strb;
  logic [WORD_W-1:0] beatWord;

  wline_ctrl #(
    .LINE_BYTES(LINE_BYTES),
    .BEAT_BYTES(BEAT_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inCmd    (inCmd),
    .inBe     (inBe),
    .beatWord (beatWord),
    .outValid (outValid),
    .outReady (outReady),
    .inReady  (inReady),
    .strb     (strb),
    .cmdReject(cmdReject),
    .wiError  (wiError)
  );

  wline_datapath #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .BEAT_BYTES(BEAT_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inAddr     (inAddr),
    .inData     (inData),
    .inBe       (inBe),
    .outReady   (outReady),
    .beatWord   (beatWord),
    .outValid   (outValid),
    .outLineAddr(outLineAddr),
    .outData    (outData),
    .outMask    (outMask),
    .outFull    (outFull)
  );

endmodule

// File: rtl/wline_checker.sv
module wline_checker #(
  parameter int LINE_BYTES = 32,
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inReady,
  input logic                  outValid,
  input logic                  outReady,
  input logic [LINE_BITS-1:0]  outData,
  input logic [LINE_BYTES-1:0] outMask,
  input logic                  outFull,
  input logic                  cmdReject,
  input logic                  wiError
);

  logic [LINE_BITS-1:0] maskBits;
  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_expand
    assign maskBits[i*8 +: 8] = {8{outMask[i]}};
  end

  p_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) &&
                                 $stable(outMask) && $stable(outFull)));

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outData & ~maskBits) == '0));

  p_full_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFull) |-> (&outMask));

  p_err_partial_r10: assert property (@(posedge clk) disable iff (!rstN)
    wiError |-> (outValid && !outFull));

  p_no_pkt_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> !$rose(outValid));

endmodule

bind wline_accum wline_checker #(.LINE_BYTES(LINE_BYTES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outMask  (outMask),
  .outFull  (outFull),
  .cmdReject(cmdReject),
  .wiError  (wiError)
);

// File: tb/wline_accum_test.sv
module wline_accum_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [29:0]  inAddr;
  logic [1:0]   inCmd;
  logic [31:0]  inData;
  logic [3:0]   inBe;
  logic         inLast;
  logic         outValid;
  logic         outReady;
  logic [26:0]  outLineAddr;
  logic [255:0] outData;
  logic [31:0]  outMask;
  logic         outFull;
  logic         cmdReject;
  logic         wiError;

  wline_accum uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inCmd(inCmd), .inData(inData), .inBe(inBe),
    .inLast(inLast), .outValid(outValid), .outReady(outReady),
    .outLineAddr(outLineAddr), .outData(outData), .outMask(outMask),
    .outFull(outFull), .cmdReject(cmdReject), .wiError(wiError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int dutPkts = 0;
  int dataCnt = 0;
  int readyMode = 0;       // 0 always ready, 1 pseudo random, 2 held low
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // output-side ready pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = lfsr[0] | lfsr[3];
      default: outReady = 1'b0;
    endcase
  end

  // behavioural reference model
  int           mState;    // 0 idle, 1 collecting, 2 draining unclaimed
  int           mWord;
  logic [26:0]  mLine;
  logic [255:0] mBuf;
  logic [31:0]  mMsk;
  bit           mInv, mOk;
  bit           mOutValid, mOutFull, mRej, mErr;
  logic [26:0]  mOutLine;
  logic [255:0] mOutData;
  logic [31:0]  mOutMask;

  always @(posedge clk) begin
    bit rdy, take, closing;
    if (!rstN) begin
      mState = 0; mWord = 0; mLine = '0; mBuf = '0; mMsk = '0;
      mInv = 0; mOk = 0; mOutValid = 0; mOutFull = 0; mRej = 0; mErr = 0;
      mOutLine = '0; mOutData = '0; mOutMask = '0;
    end else begin
      rdy  = !mOutValid || outReady;
      take = inValid && rdy;
      if (mOutValid && outReady) mOutValid = 0;
      mRej = 0; mErr = 0;
      if (take) begin
        if (mState == 0 && inCmd >= 2) begin
          mRej = 1;
          mState = inLast ? 0 : 2;
        end else if (mState == 2) begin
          if (inLast) mState = 0;
        end else begin
          if (mState == 0) begin
            mInv  = (inCmd == 2'b01);
            mLine = inAddr[29:3];
            mWord = int'(inAddr[2:0]);
            mBuf  = '0; mMsk = '0;
            mOk   = (mWord == 0);
          end
          for (int i = 0; i < 4; i++)
            if (inBe[i]) begin
              mBuf[(mWord*4+i)*8 +: 8] = inData[i*8 +: 8];
              mMsk[mWord*4+i] = 1'b1;
            end
          if (inBe != 4'hF) mOk = 0;
          closing = inLast || (mWord == 7);
          if (closing) begin
            mOutValid = 1;
            mOutLine  = mLine;
            mOutData  = mBuf;
            mOutMask  = mMsk;
            mOutFull  = mInv && mOk && (mWord == 7);
            mErr      = mInv && !mOutFull;
            mBuf = '0; mMsk = '0; mOk = 1;
            if (mWord == 7) begin mLine = mLine + 1; mWord = 0; end
          end else begin
            mWord = mWord + 1;
          end
          mState = inLast ? 0 : 1;
        end
      end
      #2;
      check(inReady === (!mOutValid || outReady), "R7", "inReady", inReady, !mOutValid || outReady);
      check(outValid === mOutValid, "R6", "outValid", outValid, mOutValid);
      if (mOutValid) begin
        check(outLineAddr === mOutLine, "R2", "outLineAddr", outLineAddr, mOutLine);
        check(outMask === mOutMask, "R3", "outMask", outMask, mOutMask);
        check(outData === mOutData, "R3", "outData", outData, mOutData);
        check(outFull === mOutFull, "R9", "outFull", outFull, mOutFull);
      end
      check(cmdReject === mRej, "R8", "cmdReject", cmdReject, mRej);
      check(wiError === mErr, "R10", "wiError", wiError, mErr);
      if (outValid && outReady) dutPkts++;
    end
  end

  task automatic waitAccept();
    bit acc = 0;
    while (!acc) begin
      #(CLK_PERIOD/2 - 1);
      acc = inReady;
      @(negedge clk);
    end
  endtask

  // later beats carry junk address/command, which must be ignored
  task automatic burst(input logic [29:0] wa, input logic [1:0] cmd, input int n,
                       input int partAt, input logic [3:0] partBe);
    for (int k = 0; k < n; k++) begin
      inAddr  = (k == 0) ? wa : (30'h2AAA5555 ^ 30'(k * 977));
      inCmd   = (k == 0) ? cmd : ~cmd;
      inBe    = (k == partAt) ? partBe : 4'hF;
      inLast  = (k == n - 1);
      inData  = 32'(dataCnt) * 32'h01010101 + 32'h10203040;
      dataCnt++;
      inValid = 1'b1;
      waitAccept();
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic expectPkts(input int mark, input int n, input string req);
    repeat (4) @(negedge clk);
    check(dutPkts - mark == n, req, "packet count", dutPkts - mark, n);
  endtask

  int mark;

  initial begin
    rstN = 1'b0; inValid = 1'b0; inAddr = '0; inCmd = '0; inData = '0;
    inBe = '0; inLast = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1", "outValid in reset", outValid, 0);
    check(inReady === 1'b1, "R1", "inReady in reset", inReady, 1);
    check(cmdReject === 1'b0 && wiError === 1'b0, "R1", "pulses in reset",
          {cmdReject, wiError}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1", "outValid after reset", outValid, 0);

    // R4: aligned full line, plain write never full (R9)
    mark = dutPkts; burst(30'h0000_0400, 2'b00, 8, -1, 4'h0); expectPkts(mark, 1, "R4");
    // R4: start at word 5, crosses into next line
    mark = dutPkts; burst(30'h0000_0805, 2'b00, 6, -1, 4'h0); expectPkts(mark, 2, "R4");
    // R5: early disconnect with partial enables (R3)
    mark = dutPkts; burst(30'h0000_0902, 2'b00, 2, 1, 4'b0101); expectPkts(mark, 1, "R5");
    // R5: single beat on the last word
    mark = dutPkts; burst(30'h0000_0C07, 2'b00, 1, 0, 4'b1000); expectPkts(mark, 1, "R5");
    // R9: complete write-and-invalidate line
    mark = dutPkts; burst(30'h0000_0A00, 2'b01, 8, -1, 4'h0); expectPkts(mark, 1, "R9");
    // R10: misaligned, early end, partial enables
    mark = dutPkts; burst(30'h0000_0B01, 2'b01, 7, -1, 4'h0); expectPkts(mark, 1, "R10");
    mark = dutPkts; burst(30'h0000_0D00, 2'b01, 4, -1, 4'h0); expectPkts(mark, 1, "R10");
    mark = dutPkts; burst(30'h0000_0E00, 2'b01, 8, 3, 4'b1110); expectPkts(mark, 1, "R10");
    // R8: unclaimed commands
    mark = dutPkts; burst(30'h0000_0F00, 2'b10, 3, -1, 4'h0); expectPkts(mark, 0, "R8");
    mark = dutPkts; burst(30'h0000_0F10, 2'b11, 1, -1, 4'h0); expectPkts(mark, 0, "R8");

    // R7: upstream holds off, next beat must stall
    readyMode = 2;
    @(negedge clk);
    burst(30'h0000_1003, 2'b00, 1, -1, 4'h0);
    inAddr = 30'h0000_1104; inCmd = 2'b00; inBe = 4'hF; inLast = 1'b1;
    inData = 32'hCAFEF00D; inValid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(inReady === 1'b0, "R7", "inReady while blocked", inReady, 0);
    check(outValid === 1'b1, "R6", "packet held while blocked", outValid, 1);
    readyMode = 0;
    @(negedge clk);
    waitAccept();
    inValid = 1'b0; inLast = 1'b0;

    // random backpressure over mixed traffic
    readyMode = 1;
    for (int r = 0; r < 40; r++) begin
      burst(30'(32'h2000 + r * 11), 2'(r % 3), 1 + (r * 7) % 19, r % 5, 4'(r));
      burst(30'(32'h3000 + r * 8), 2'b01, 16, -1, 4'h0);
    end
    readyMode = 0;
    repeat (6) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule